// File: doc/BRIEF.md
# In-Order Commit Head Controller

This block keeps the head end of a circular reorder buffer. The rename stage appends one entry per cycle at the tail, carrying a sequence number and a flag that marks the entry non-speculative. The execute stage marks entries complete by buffer index. Every cycle the controller retires a run of completed entries from the head, up to a configurable commit width, and reports how many it retired and their sequence numbers, oldest first.

A non-speculative entry may not run until it is the oldest entry in the buffer. When such an entry reaches the head, the controller sends a one-cycle release pulse with its sequence number back to the issue logic. It then holds retirement until the completion mark for that entry arrives. Only the head can be released, so at most one such entry is handled per cycle. A stall counter counts the cycles spent waiting in this way.

The controller also reports the number of free entries, with a strobe in each cycle where the value changed, and a full flag while no entry is free. It handles a single thread.

Top module: `cmt_head_ctrl`

## Requirements
- R1: In each cycle the block retires up to WIDTH consecutive entries from the head that are ready. A plain entry is ready once it is complete, and a non-speculative entry once it has been released and is complete. In the cycle after the clock edge, `ret_count` gives the number retired and slot i of `ret_seq` (bits i*SEQ_W upward) holds the sequence number of the i-th oldest retired entry. Unused slots read zero.
- R2: Retirement stops at the first entry that is not ready, even if younger entries are complete.
- R3: When the head entry is non-speculative and not yet released, `rel_valid` is high for the one cycle after that clock edge and `rel_seq` carries the entry's sequence number. `rel_seq` reads zero when `rel_valid` is low.
- R4: At most one release happens per cycle, and no entry is released twice.
- R5: A released non-speculative entry retires only after its completion mark arrives. Until then, younger completed entries do not retire.
- R6: After each clock edge, `free_cnt` equals DEPTH minus the occupancy. `free_upd` is high in exactly the cycles after an edge where the occupancy changed.
- R7: `full` is high while the occupancy equals DEPTH. An insertion offered while `full` is high is dropped and never retires.
- R8: `stall_cnt` increases by one, saturating, at every edge where the head is a non-speculative entry that has not been both released and completed. Otherwise it holds.
- R9: Entries are stored at consecutive indices that wrap modulo DEPTH, starting at index 0 after reset, and they retire in insertion order. A completion mark for an index that holds no entry has no effect, including on an entry later written to that index.
- R10: After reset the buffer is empty. `free_cnt` is DEPTH, and `full`, `free_upd`, `rel_valid`, `ret_count` and `stall_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Rename offers an entry this cycle |
| ins_nonspec | input | 1 | Offered entry is non-speculative |
| ins_seq | input | SEQ_W | Sequence number of the offered entry |
| done_valid | input | 1 | Execute marks an entry complete |
| done_idx | input | IDX_W | Buffer index being marked complete |
| full | output | 1 | No free entry; insertions are dropped |
| ret_count | output | CNT_W | Number of entries retired at the last edge |
| ret_seq | output | WIDTH*SEQ_W | Retired sequence numbers, slot 0 oldest |
| rel_valid | output | 1 | Release pulse for the head non-speculative entry |
| rel_seq | output | SEQ_W | Sequence number being released |
| free_cnt | output | OCC_W | Free entries after the last edge |
| free_upd | output | 1 | free_cnt changed at the last edge |
| stall_cnt | output | STALL_W | Cycles the head waited on a non-speculative entry |

## Verification
An insertion or completion mark presented before edge k changes the state at edge k. A completed entry can therefore first retire at edge k+1, and its count and sequence number appear after that edge. A release pulse appears right after the edge at which the head, as it stood before the edge, was an unreleased non-speculative entry. `free_cnt`, `free_upd` and `stall_cnt` reflect edge k as soon as it passes, and `full` follows the registered occupancy. The bench drives inputs and samples outputs on the falling edge. Its reference model steps once per rising edge using the state it held before that edge, so each result is compared in the same half-cycle the block produces it.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  // Advance a ring position by a step smaller than the ring size.
  function automatic int wrap_add(int pos, int step, int depth);
    int s;
    s = pos + step;
    return (s >= depth) ? s - depth : s;
  endfunction

  // Distance from base forward to pos around the ring.
  function automatic int ring_dist(int pos, int base, int depth);
    return (pos >= base) ? pos - base : pos + depth - base;
  endfunction

  // Free entries for a given occupancy.
  function automatic int free_of(int occ, int depth);
    return depth - occ;
  endfunction

endpackage

// File: rtl/cmt_entry_store.sv
module cmt_entry_store #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ins_fire,
  input  logic                          ins_ns,
  input  logic [SEQ_W-1:0]              ins_seq,
  input  logic [IDX_W-1:0]              tail,
  input  logic                          done_valid,
  input  logic [IDX_W-1:0]              done_idx,
  input  logic                          rel_fire,
  input  logic [IDX_W-1:0]              head,
  input  logic [CNT_W-1:0]              retire_n,
  output logic [DEPTH-1:0]              valid_o,
  output logic [DEPTH-1:0]              done_o,
  output logic [DEPTH-1:0]              ns_o,
  output logic [DEPTH-1:0]              rel_o,
  output logic [DEPTH-1:0][SEQ_W-1:0]   seq_o
);

  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(j);
    logic retire_hit;
    logic mark_hit;

    assign retire_hit = cmt_pkg::ring_dist(j, int'(head), DEPTH) < int'(retire_n);
    assign mark_hit   = done_valid && (done_idx == MY_IDX) && valid_o[j];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_o[j] <= 1'b0;
        done_o[j]  <= 1'b0;
        ns_o[j]    <= 1'b0;
        rel_o[j]   <= 1'b0;
        seq_o[j]   <= '0;
      end else begin
        if (retire_hit) begin
          valid_o[j] <= 1'b0;
          done_o[j]  <= 1'b0;
          ns_o[j]    <= 1'b0;
          rel_o[j]   <= 1'b0;
        end else begin
          if (mark_hit) done_o[j] <= 1'b1;
          if (rel_fire && head == MY_IDX) rel_o[j] <= 1'b1;
        end
        if (ins_fire && tail == MY_IDX) begin
          valid_o[j] <= 1'b1;
          done_o[j]  <= 1'b0;
          ns_o[j]    <= ins_ns;
          rel_o[j]   <= 1'b0;
          seq_o[j]   <= ins_seq;
        end
      end
    end
  end

endmodule

// File: rtl/cmt_retire_pick.sv
module cmt_retire_pick #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 3
) (
  input  logic [DEPTH-1:0]              valid_i,
  input  logic [DEPTH-1:0]              done_i,
  input  logic [DEPTH-1:0]              ns_i,
  input  logic [DEPTH-1:0]              rel_i,
  input  logic [DEPTH-1:0][SEQ_W-1:0]   seq_i,
  input  logic [IDX_W-1:0]              head,
  output logic [CNT_W-1:0]              retire_n,
  output logic [WIDTH-1:0][SEQ_W-1:0]   slot_seq,
  output logic                          rel_fire,
  output logic [SEQ_W-1:0]              rel_seq,
  output logic                          head_wait
);

  logic [WIDTH-1:0] ok;
  logic [WIDTH-1:0] run;
  logic [WIDTH-1:0][IDX_W-1:0] pos;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slot
    assign pos[i] = IDX_W'(cmt_pkg::wrap_add(int'(head), i, DEPTH));
    assign ok[i]  = valid_i[pos[i]] && done_i[pos[i]] && (!ns_i[pos[i]] || rel_i[pos[i]]);
  end

  always_comb begin
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < WIDTH; i++) begin
      acc    = acc & ok[i];
      run[i] = acc;
    end
  end

  assign retire_n = CNT_W'($countones(run));

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    assign slot_seq[i] = run[i] ? seq_i[pos[i]] : '0;
  end

  assign rel_fire  = valid_i[head] && ns_i[head] && !rel_i[head];
  assign rel_seq   = seq_i[head];
  assign head_wait = valid_i[head] && ns_i[head] && !(rel_i[head] && done_i[head]);

endmodule

// File: rtl/cmt_occupancy_report.sv
module cmt_occupancy_report #(
  parameter int DEPTH   = 16,
  parameter int OCC_W   = 5,
  parameter int STALL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OCC_W-1:0]   occ_now,
  input  logic [OCC_W-1:0]   occ_next,
  input  logic               head_wait,
  output logic [OCC_W-1:0]   free_cnt,
  output logic               free_upd,
  output logic [STALL_W-1:0] stall_cnt
);

  localparam logic [STALL_W-1:0] STALL_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_cnt  <= OCC_W'(DEPTH);
      free_upd  <= 1'b0;
      stall_cnt <= '0;
    end else begin
      free_cnt <= OCC_W'(cmt_pkg::free_of(int'(occ_next), DEPTH));
      free_upd <= (occ_next != occ_now);
      if (head_wait && stall_cnt != STALL_MAX) stall_cnt <= stall_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cmt_head_ctrl.sv
module cmt_head_ctrl #(
  parameter int DEPTH   = 16,
  parameter int WIDTH   = 4,
  parameter int SEQ_W   = 16,
  parameter int STALL_W = 16,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W  = $clog2(DEPTH + 1),
  localparam int CNT_W  = $clog2(WIDTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_valid,
  input  logic                     ins_nonspec,
  input  logic [SEQ_W-1:0]         ins_seq,
  input  logic                     done_valid,
  input  logic [IDX_W-1:0]         done_idx,
  output logic                     full,
  output logic [CNT_W-1:0]         ret_count,
  output logic [WIDTH*SEQ_W-1:0]   ret_seq,
  output logic                     rel_valid,
  output logic [SEQ_W-1:0]         rel_seq,
  output logic [OCC_W-1:0]         free_cnt,
  output logic                     free_upd,
  output logic [STALL_W-1:0]       stall_cnt
);

  logic [IDX_W-1:0] head_q, tail_q;
  logic [OCC_W-1:0] occ_q, occ_next;
  logic             ins_fire;

  logic [DEPTH-1:0]            e_valid, e_done, e_ns, e_rel;
  logic [DEPTH-1:0][SEQ_W-1:0] e_seq;

  logic [CNT_W-1:0]            retire_n;
  logic [WIDTH-1:0][SEQ_W-1:0] slot_seq;
  logic                        rel_fire;
  logic [SEQ_W-1:0]            head_seq;
  logic                        head_wait;

  logic [CNT_W-1:0]            ret_count_q;
  logic [WIDTH-1:0][SEQ_W-1:0] ret_seq_q;
  logic                        rel_valid_q;
  logic [SEQ_W-1:0]            rel_seq_q;

  assign full     = (occ_q == OCC_W'(DEPTH));
  assign ins_fire = ins_valid && !full;
  assign occ_next = occ_q - OCC_W'(retire_n) + OCC_W'(ins_fire);

  cmt_entry_store #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .ins_fire(ins_fire), .ins_ns(ins_nonspec), .ins_seq(ins_seq), .tail(tail_q),
    .done_valid(done_valid), .done_idx(done_idx),
    .rel_fire(rel_fire), .head(head_q), .retire_n(retire_n),
    .valid_o(e_valid), .done_o(e_done), .ns_o(e_ns), .rel_o(e_rel), .seq_o(e_seq)
  );

  cmt_retire_pick #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_pick (
    .valid_i(e_valid), .done_i(e_done), .ns_i(e_ns), .rel_i(e_rel), .seq_i(e_seq),
    .head(head_q), .retire_n(retire_n), .slot_seq(slot_seq),
    .rel_fire(rel_fire), .rel_seq(head_seq), .head_wait(head_wait)
  );

  cmt_occupancy_report #(
    .DEPTH(DEPTH), .OCC_W(OCC_W), .STALL_W(STALL_W)
  ) u_report (
    .clk(clk), .rst_n(rst_n), .occ_now(occ_q), .occ_next(occ_next),
    .head_wait(head_wait), .free_cnt(free_cnt), .free_upd(free_upd),
    .stall_cnt(stall_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q      <= '0;
      tail_q      <= '0;
      occ_q       <= '0;
      ret_count_q <= '0;
      ret_seq_q   <= '0;
      rel_valid_q <= 1'b0;
      rel_seq_q   <= '0;
    end else begin
      head_q      <= IDX_W'(cmt_pkg::wrap_add(int'(head_q), int'(retire_n), DEPTH));
      if (ins_fire) tail_q <= IDX_W'(cmt_pkg::wrap_add(int'(tail_q), 1, DEPTH));
      occ_q       <= occ_next;
      ret_count_q <= retire_n;
      ret_seq_q   <= slot_seq;
      rel_valid_q <= rel_fire;
      rel_seq_q   <= rel_fire ? head_seq : '0;
    end
  end

  assign ret_count = ret_count_q;
  assign ret_seq   = ret_seq_q;
  assign rel_valid = rel_valid_q;
  assign rel_seq   = rel_seq_q;

endmodule

// File: rtl/cmt_head_ctrl_chk.sv
module cmt_head_ctrl_chk #(
  parameter int DEPTH   = 16,
  parameter int WIDTH   = 4,
  parameter int STALL_W = 16,
  localparam int OCC_W  = $clog2(DEPTH + 1),
  localparam int CNT_W  = $clog2(WIDTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ins_valid,
  input logic               full,
  input logic [CNT_W-1:0]   ret_count,
  input logic [OCC_W-1:0]   free_cnt,
  input logic               free_upd,
  input logic               rel_valid,
  input logic [STALL_W-1:0] stall_cnt,
  input logic               head_wait
);

  localparam logic [STALL_W-1:0] STALL_MAX = '1;

  p_ret_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ret_count) <= WIDTH);

  p_drop_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && ins_valid) |=> (free_cnt == OCC_W'(ret_count)));

  p_upd_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    free_upd |-> (free_cnt != $past(free_cnt)));

  p_quiet_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !free_upd |-> $stable(free_cnt));

  p_rel_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |=> !rel_valid);

  p_rel_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> $past(head_wait));

  p_stall_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (head_wait && stall_cnt != STALL_MAX) |=> ((stall_cnt - $past(stall_cnt)) == STALL_W'(1)));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !head_wait |=> $stable(stall_cnt));

endmodule

bind cmt_head_ctrl cmt_head_ctrl_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .STALL_W(STALL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .full(full),
  .ret_count(ret_count), .free_cnt(free_cnt), .free_upd(free_upd),
  .rel_valid(rel_valid), .stall_cnt(stall_cnt), .head_wait(head_wait)
);

// File: tb/sim_cmt_head_ctrl.sv
`timescale 1ns/1ps
module sim_cmt_head_ctrl;

  localparam int D  = 8;
  localparam int W  = 3;
  localparam int SW = 12;
  localparam int STW = 16;
  localparam int IW = 3;
  localparam int OW = 4;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0, ins_nonspec = 1'b0, done_valid = 1'b0;
  logic [SW-1:0] ins_seq = '0;
  logic [IW-1:0] done_idx = '0;
  logic full, rel_valid, free_upd;
  logic [CW-1:0] ret_count;
  logic [W*SW-1:0] ret_seq;
  logic [SW-1:0] rel_seq;
  logic [OW-1:0] free_cnt;
  logic [STW-1:0] stall_cnt;

  always #10 clk = ~clk;

  cmt_head_ctrl #(.DEPTH(D), .WIDTH(W), .SEQ_W(SW), .STALL_W(STW)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_nonspec(ins_nonspec),
    .ins_seq(ins_seq), .done_valid(done_valid), .done_idx(done_idx), .full(full),
    .ret_count(ret_count), .ret_seq(ret_seq), .rel_valid(rel_valid), .rel_seq(rel_seq),
    .free_cnt(free_cnt), .free_upd(free_upd), .stall_cnt(stall_cnt)
  );

  typedef struct { int seq; bit ns; bit done; bit rel; int idx; } ent_t;
  ent_t q[$];
  int m_tail = 0;
  int m_stall = 0;
  int exp_n = 0, exp_rel = 0, exp_rel_seq = 0, exp_free = D, exp_upd = 0, exp_full = 0;
  int exp_seq[W];
  int compared = 0, mismatched = 0;

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1", "ret_count", int'(ret_count), exp_n);
    for (int i = 0; i < W; i++)
      chk("R1", "ret_seq slot", int'(ret_seq[i*SW +: SW]), exp_seq[i]);
    chk("R3", "rel_valid", int'(rel_valid), exp_rel);
    chk("R3", "rel_seq", int'(rel_seq), exp_rel_seq);
    chk("R6", "free_cnt", int'(free_cnt), exp_free);
    chk("R6", "free_upd", int'(free_upd), exp_upd);
    chk("R7", "full", int'(full), exp_full);
    chk("R8", "stall_cnt", int'(stall_cnt), m_stall);
  endtask

  task automatic model_step(bit iv, bit ns, int sq, bit dv, int di);
    int n, old;
    bit go, relf, acc;
    ent_t e;
    old = q.size();
    n = 0; go = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (go && i < q.size() && q[i].done && (!q[i].ns || q[i].rel)) n++;
      else go = 1'b0;
    end
    relf = (q.size() > 0) && q[0].ns && !q[0].rel;
    if (q.size() > 0 && q[0].ns && !(q[0].rel && q[0].done) && m_stall < 65535) m_stall++;
    if (dv) for (int k = 0; k < q.size(); k++) if (q[k].idx == di) q[k].done = 1'b1;
    acc = iv && (q.size() != D);
    exp_rel = relf ? 1 : 0;
    exp_rel_seq = relf ? q[0].seq : 0;
    if (relf) q[0].rel = 1'b1;
    for (int i = 0; i < W; i++) exp_seq[i] = (i < n) ? q[i].seq : 0;
    exp_n = n;
    for (int i = 0; i < n; i++) void'(q.pop_front());
    if (acc) begin
      e.seq = sq; e.ns = ns; e.done = 1'b0; e.rel = 1'b0; e.idx = m_tail;
      q.push_back(e);
      m_tail = (m_tail + 1) % D;
    end
    exp_free = D - q.size();
    exp_upd  = (q.size() != old) ? 1 : 0;
    exp_full = (q.size() == D) ? 1 : 0;
  endtask

  task automatic cyc(bit iv, bit ns, int sq, bit dv, int di);
    ins_valid = iv; ins_nonspec = ns; ins_seq = SW'(sq);
    done_valid = dv; done_idx = IW'(di);
    @(posedge clk);
    model_step(iv, ns, sq, dv, di);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 100000);
    mismatched++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < W; i++) exp_seq[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    chk("R10", "free_cnt", int'(free_cnt), D);
    chk("R10", "full", int'(full), 0);
    chk("R10", "ret_count", int'(ret_count), 0);
    chk("R10", "rel_valid", int'(rel_valid), 0);
    chk("R10", "stall_cnt", int'(stall_cnt), 0);
    chk("R10", "free_upd", int'(free_upd), 0);

    // Out-of-order completion; retirement stops at first incomplete entry
    for (int s = 1; s <= 5; s++) cyc(1, 0, s, 0, 0);
    cyc(0, 0, 0, 1, 2);
    cyc(0, 0, 0, 1, 0);
    idle(1);
    chk("R2", "ret_count stop", int'(ret_count), 1);
    chk("R2", "ret_seq oldest", int'(ret_seq[0 +: SW]), 1);
    cyc(0, 0, 0, 1, 1);
    idle(1);
    chk("R1", "ret_count pair", int'(ret_count), 2);
    chk("R1", "ret_seq slot1", int'(ret_seq[SW +: SW]), 3);

    // R9: a mark on an empty index does not pre-complete a later entry there
    cyc(0, 0, 0, 1, 6);
    cyc(1, 0, 6, 0, 0);
    cyc(1, 0, 7, 0, 0);
    cyc(0, 0, 0, 1, 3);
    cyc(0, 0, 0, 1, 4);
    cyc(0, 0, 0, 1, 5);
    idle(2);
    chk("R9", "ret_count idle", int'(ret_count), 0);
    chk("R9", "free_cnt left", int'(free_cnt), D - 1);
    cyc(0, 0, 0, 1, 6);
    idle(2);

    // R7: fill, offer while full, drain
    for (int s = 10; s < 10 + D; s++) cyc(1, 0, s, 0, 0);
    chk("R7", "full set", int'(full), 1);
    cyc(1, 0, 99, 0, 0);
    chk("R7", "free_cnt full", int'(free_cnt), 0);
    for (int k = 0; k < D; k++) cyc(0, 0, 0, 1, (7 + k) % D);
    idle(4);
    chk("R7", "free_cnt drained", int'(free_cnt), D);

    // Non-speculative entry behind a plain one, younger one complete
    cyc(1, 0, 20, 0, 0);
    cyc(1, 1, 21, 0, 0);
    cyc(1, 0, 22, 0, 0);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 0, 1, 7);
    idle(1);
    idle(1);
    chk("R3", "rel_valid pulse", int'(rel_valid), 1);
    chk("R3", "rel_seq value", int'(rel_seq), 21);
    idle(1);
    chk("R4", "no repeat", int'(rel_valid), 0);
    chk("R5", "held behind", int'(ret_count), 0);
    idle(1);
    chk("R4", "no repeat late", int'(rel_valid), 0);
    cyc(0, 0, 0, 1, 0);
    idle(1);
    chk("R5", "retire after done", int'(ret_count), 2);
    chk("R8", "stall total", int'(stall_cnt), 4);

    // Back-to-back non-speculative entries
    cyc(1, 1, 30, 0, 0);
    cyc(1, 1, 31, 0, 0);
    idle(2);
    cyc(0, 0, 0, 1, 2);
    idle(2);
    cyc(0, 0, 0, 1, 3);
    idle(3);

    // Mixed traffic, wraps many times
    for (int t = 0; t < 1500; t++) begin
      bit iv, ns, dv;
      int di, k;
      iv = ($urandom_range(3) != 0);
      ns = ($urandom_range(5) == 0);
      dv = 1'b0; di = 0;
      if ($urandom_range(16) == 0) begin
        dv = 1'b1; di = $urandom_range(D - 1);
      end else if (q.size() > 0 && $urandom_range(2) != 0) begin
        k = $urandom_range(q.size() - 1);
        if (!q[k].ns || q[k].rel) begin dv = 1'b1; di = q[k].idx; end
      end
      cyc(iv, ns, (100 + t) % 4096, dv, di);
    end
    for (int t = 0; t < 60; t++) begin
      if (q.size() > 0 && (!q[0].ns || q[0].rel)) cyc(0, 0, 0, 1, q[0].idx);
      else idle(1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule